// File: doc/BRIEF.md
# Fractional-Interval Frame Request Generator

This block paces a streaming audio link. It issues a frame request to the bus side on a deadline that repeats about once per frame period. The deadline moves forward by a whole number of reference cycles taken from the selected sample rate. A fractional accumulator adds one extra cycle whenever it wraps. Over many frames the average interval therefore equals the exact fractional value. For example, a 1 ms frame at 44.1 kHz carries 44.1 samples per channel on average.

A request goes out only when the bus side has acknowledged the previous one. If a deadline arrives while a request is still outstanding, that deadline is skipped and is not queued. The sample-rate code can change at run time. A new code is picked up at the next deadline, and the fractional accumulator restarts from zero at that point.

The same block splits one interleaved stereo word stream into a left output and a right output. Each output has its own holding register and a one-cycle strobe. A resync input realigns the stream onto the left channel. The reset input must be deasserted synchronously to `clk`.

Top module: `frame_req_gen`

## Requirements
- R1: During reset `frame_req`, `left_stb` and `right_stb` are low. With rate code 0 selected, the first deadline falls `RATE_INT[0]` cycles after reset is released. Its request is visible in that cycle.
- R2: After each deadline, the next deadline follows after the whole part of the rate currently in use, plus any carry. The defaults are: code 0 = 10 + 64/256, code 1 = 11 + 0/256, code 2 = 9 + 128/256, code 3 = 12 + 192/256 cycles.
- R3: At every deadline the accumulator (`FRAC_W` bits) adds the fractional part of the rate. A wrap lengthens the interval that starts at that deadline by one cycle. The N-th interval of an epoch, counting from 0, lasts INT + floor((N+1)·F/2^FRAC_W) − floor(N·F/2^FRAC_W).
- R4: `frame_req` is a pulse one cycle wide. It is registered, so it appears in the cycle after the clock edge at which the deadline was reached.
- R5: While a request is outstanding (issued but not yet acknowledged), a deadline produces no request and is dropped. Deadlines keep their timing regardless.
- R6: A `frame_ack` pulse when no request is outstanding has no effect. A deadline that meets an acknowledge on the same edge is still skipped.
- R7: `rate_sel` is sampled only at a deadline. If it differs from the code in use, the new code is adopted there and the accumulator is cleared. The interval that ended at that deadline keeps its old length.
- R8: The first valid word after reset goes to the left output, and later valid words alternate right, left, right.
- R9: `smp_resync` with a valid word sends that word to the left output. `smp_resync` without a valid word makes the next valid word left.
- R10: A valid word appears on its channel's data output one cycle later, with exactly one strobe high. Each data output holds its value until the next word for that channel arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset, deasserted synchronously |
| rate_sel | input | RATE_W | Sample-rate code, applied at the next deadline |
| frame_ack | input | 1 | Acknowledge of the outstanding frame request |
| frame_req | output | 1 | Frame request pulse |
| smp_valid | input | 1 | Interleaved sample word valid |
| smp_resync | input | 1 | Force the current or next word to the left channel |
| smp_data | input | SMP_W | Interleaved sample word |
| left_stb | output | 1 | New left word present |
| left_data | output | SMP_W | Held left word |
| right_stb | output | 1 | New right word present |
| right_data | output | SMP_W | Held right word |

## Verification
Every cycle, the assertions check the following:
- the request is a single-cycle pulse and never appears while an earlier one is unacknowledged;
- each valid word produces exactly one channel strobe, and no strobe appears without a word;
- the stream alternates channels, and resync lands on the left channel.

Only the bench's scenarios can show the timing properties. These are the exact interval length as the accumulator carries, the first deadline after reset, the dropping of deadlines during a long acknowledge stall, and the point where a rate change takes effect and clears the accumulator. The bench predicts each deadline from a closed-form fixed-point schedule.

// File: rtl/frg_pkg.sv
package frg_pkg;
  typedef enum logic { CH_LEFT = 1'b0, CH_RIGHT = 1'b1 } chan_e;
endpackage

// File: rtl/frg_interval_timer.sv
module frg_interval_timer #(
  parameter int CNT_W     = 8,
  parameter int FRAC_W    = 8,
  parameter int NUM_RATES = 4,
  parameter int RATE_W    = 2,
  parameter logic [NUM_RATES*CNT_W-1:0]  RATE_INT  = '0,
  parameter logic [NUM_RATES*FRAC_W-1:0] RATE_FRAC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              tick
);
  logic [CNT_W-1:0]  int_tbl  [NUM_RATES];
  logic [FRAC_W-1:0] frac_tbl [NUM_RATES];

  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_tbl
    assign int_tbl[gi]  = RATE_INT[gi*CNT_W +: CNT_W];
    assign frac_tbl[gi] = RATE_FRAC[gi*FRAC_W +: FRAC_W];
  end

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [RATE_W-1:0] act_q, act_d;
  logic              rate_chg;
  logic [RATE_W-1:0] use_rate;
  logic [FRAC_W-1:0] acc_base;
  logic [FRAC_W:0]   sum;
  logic              carry;

  always_comb begin
    tick     = (cnt_q == '0);
    rate_chg = (rate_sel != act_q);
    use_rate = rate_chg ? rate_sel : act_q;
    acc_base = rate_chg ? '0 : acc_q;
    sum      = {1'b0, acc_base} + {1'b0, frac_tbl[use_rate]};
    carry    = sum[FRAC_W];
    cnt_d    = cnt_q - 1'b1;
    acc_d    = acc_q;
    act_d    = act_q;
    if (tick) begin
      cnt_d = int_tbl[use_rate] + {{(CNT_W-1){1'b0}}, carry} - 1'b1;
      acc_d = sum[FRAC_W-1:0];
      act_d = use_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RATE_INT[CNT_W-1:0] - 1'b1;
      acc_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/frg_handshake.sv
module frg_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ack,
  output logic req
);
  logic pend_q, pend_d, req_d, fire;

  always_comb begin
    fire   = tick & ~pend_q;
    req_d  = fire;
    pend_d = pend_q;
    if (fire)     pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req    <= req_d;
    end
  end
endmodule

// File: rtl/frg_splitter.sv
module frg_splitter
  import frg_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             resync,
  input  logic [SMP_W-1:0] data,
  output logic             l_stb,
  output logic [SMP_W-1:0] l_data,
  output logic             r_stb,
  output logic [SMP_W-1:0] r_data
);
  chan_e            ph_q, ph_d;
  logic             to_left;
  logic             l_stb_d, r_stb_d;
  logic [SMP_W-1:0] l_data_d, r_data_d;

  always_comb begin
    to_left  = resync | (ph_q == CH_LEFT);
    l_stb_d  = valid & to_left;
    r_stb_d  = valid & ~to_left;
    l_data_d = l_stb_d ? data : l_data;
    r_data_d = r_stb_d ? data : r_data;
    if (valid)       ph_d = to_left ? CH_RIGHT : CH_LEFT;
    else if (resync) ph_d = CH_LEFT;
    else             ph_d = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= CH_LEFT;
      l_stb  <= 1'b0;
      r_stb  <= 1'b0;
      l_data <= '0;
      r_data <= '0;
    end else begin
      ph_q   <= ph_d;
      l_stb  <= l_stb_d;
      r_stb  <= r_stb_d;
      l_data <= l_data_d;
      r_data <= r_data_d;
    end
  end
endmodule

// File: rtl/frame_req_gen.sv
module frame_req_gen #(
  parameter int CNT_W     = 8,
  parameter int FRAC_W    = 8,
  parameter int NUM_RATES = 4,
  parameter int SMP_W     = 16,
  parameter logic [NUM_RATES*CNT_W-1:0]  RATE_INT  = {8'd12, 8'd9, 8'd11, 8'd10},
  parameter logic [NUM_RATES*FRAC_W-1:0] RATE_FRAC = {8'd192, 8'd128, 8'd0, 8'd64},
  localparam int RATE_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              frame_ack,
  output logic              frame_req,
  input  logic              smp_valid,
  input  logic              smp_resync,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              left_stb,
  output logic [SMP_W-1:0]  left_data,
  output logic              right_stb,
  output logic [SMP_W-1:0]  right_data
);
  logic deadline;

  frg_interval_timer #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .NUM_RATES(NUM_RATES), .RATE_W(RATE_W),
    .RATE_INT(RATE_INT), .RATE_FRAC(RATE_FRAC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tick(deadline)
  );

  frg_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .tick(deadline), .ack(frame_ack), .req(frame_req)
  );

  frg_splitter #(.SMP_W(SMP_W)) u_split (
    .clk(clk), .rst_n(rst_n), .valid(smp_valid), .resync(smp_resync),
    .data(smp_data), .l_stb(left_stb), .l_data(left_data),
    .r_stb(right_stb), .r_data(right_data)
  );
endmodule

// File: rtl/frg_checker.sv
module frg_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_ack,
  input logic frame_req,
  input logic smp_valid,
  input logic smp_resync,
  input logic left_stb,
  input logic right_stb
);
  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         outstanding_q <= 1'b0;
    else if (frame_ack) outstanding_q <= 1'b0;
    else if (frame_req) outstanding_q <= 1'b1;
  end

  // R4
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |=> !frame_req);
  // R5
  a_r5_no_req_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |-> !outstanding_q);
  // R10
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> $onehot({left_stb, right_stb}));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !left_stb && !right_stb);
  // R8
  a_r8_left_then_right: assert property (@(posedge clk) disable iff (!rst_n)
    (left_stb && smp_valid && !smp_resync) |=> right_stb);
  a_r8_right_then_left: assert property (@(posedge clk) disable iff (!rst_n)
    (right_stb && smp_valid) |=> left_stb);
  // R9
  a_r9_resync_left: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_resync) |=> left_stb);
endmodule

bind frame_req_gen frg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ack(frame_ack), .frame_req(frame_req),
  .smp_valid(smp_valid), .smp_resync(smp_resync),
  .left_stb(left_stb), .right_stb(right_stb)
);

// File: tb/tb_frame_req_gen.sv
module tb_frame_req_gen;
  localparam int SMP_W = 16;
  localparam int NCYC  = 6000;
  localparam int INT_T  [4] = '{10, 11, 9, 12};
  localparam int FRAC_T [4] = '{64, 0, 128, 192};

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       rate_sel;
  logic             frame_ack, frame_req;
  logic             smp_valid, smp_resync;
  logic [SMP_W-1:0] smp_data, left_data, right_data;
  logic             left_stb, right_stb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  frame_req_gen dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .frame_ack(frame_ack),
    .frame_req(frame_req), .smp_valid(smp_valid), .smp_resync(smp_resync),
    .smp_data(smp_data), .left_stb(left_stb), .left_data(left_data),
    .right_stb(right_stb), .right_data(right_data)
  );

  function automatic int gap(int r, int j);
    return INT_T[r] + ((j + 1) * FRAC_T[r]) / 256 - (j * FRAC_T[r]) / 256;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int  next_t, j, m_rate, skipped, reqs;
    bit  m_pend, ack_prev, exp_req;
    bit  ph_right, e_lstb, e_rstb;
    logic [SMP_W-1:0] e_ldata, e_rdata;
    void'($urandom(32'h5eed_0001));
    rst_n = 1'b0; rate_sel = 2'd0; frame_ack = 1'b0;
    smp_valid = 1'b0; smp_resync = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(frame_req == 1'b0, "R1 req in reset", frame_req, 0);
    chk(left_stb == 1'b0 && right_stb == 1'b0, "R1 strobes in reset",
        {left_stb, right_stb}, 0);
    rst_n = 1'b1;
    next_t = INT_T[0]; j = 0; m_rate = 0; m_pend = 0; ack_prev = 0;
    skipped = 0; reqs = 0;
    ph_right = 0; e_lstb = 0; e_rstb = 0; e_ldata = '0; e_rdata = '0;
    for (int c = 1; c <= NCYC; c++) begin
      @(negedge clk);
      // R1 R2 R3 R5 R7: predicted deadline schedule
      exp_req = (c == next_t) && !m_pend;
      chk(frame_req == exp_req, "R2 R3 R5 frame_req", frame_req, exp_req);
      if (c == next_t) begin
        if (m_pend) skipped++;
        if (int'(rate_sel) != m_rate) begin
          m_rate = int'(rate_sel);   // R7 new code, accumulator cleared
          j = 0;
        end
        next_t += gap(m_rate, j);
        j++;
      end
      if (exp_req) begin
        m_pend = 1; reqs++;
      end else if (ack_prev) m_pend = 0;
      // R8 R9 R10 splitter outputs
      chk(left_stb == e_lstb, "R8 R9 left_stb", left_stb, e_lstb);
      chk(right_stb == e_rstb, "R8 R10 right_stb", right_stb, e_rstb);
      chk(left_data == e_ldata, "R10 left_data held", left_data, e_ldata);
      chk(right_data == e_rdata, "R10 right_data held", right_data, e_rdata);
      // drive acknowledge; R6 random acks also hit idle periods
      if (c >= 2000 && c < 2400) frame_ack = 1'b0;
      else frame_ack = ($urandom % 4) == 0;
      ack_prev = frame_ack;
      // R7 occasional rate change
      if (c == 20) rate_sel = 2'd2;
      else if (($urandom % 300) == 0) rate_sel = 2'($urandom % 4);
      // samples
      if (c < 10) begin
        smp_valid = (c % 2) == 0; smp_resync = 1'b0;
      end else begin
        smp_valid  = ($urandom % 3) != 0;
        smp_resync = ($urandom % 16) == 0;
      end
      smp_data = 16'($urandom);
      e_lstb = 0; e_rstb = 0;
      if (smp_valid) begin
        if (smp_resync || !ph_right) begin
          e_lstb = 1; e_ldata = smp_data; ph_right = 1;
        end else begin
          e_rstb = 1; e_rdata = smp_data; ph_right = 0;
        end
      end else if (smp_resync) ph_right = 0;
    end
    // R5: the long stall forced skipped deadlines
    chk(skipped > 0, "R5 deadlines skipped", skipped, 1);
    chk(reqs > 100, "R2 request count", reqs, 101);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule